// File: doc/BRIEF.md
# SDRAM Bank Command Timing Guard

This block watches one SDRAM bank and decides, in the same cycle as the request, whether a requested command may go out. It knows whether the bank is idle (precharged) or open (row active). It enforces three programmable minimum spacings. The first runs from precharge to the next activate or refresh. The second runs from activate to the column commands (read or write). The third runs from activate to precharge.

The three spacings come packed in one 32-bit configuration word. The block decodes their compact codes itself. A request that is refused leaves the grant low and changes nothing, so the requester simply asks again on a later cycle. The configuration is captured only while the bank is idle, which keeps one value of each spacing in force for a whole open period.

Top module: `bank_cmd_guard`

## Requirements
- R1: After a synchronous active-low reset, the bank is idle, all captured spacing codes are zero, `cfg_err` is high and no grant is given.
- R2: `cfg_err` is high whenever the captured precharge spacing code (word bits 30:28) or the activate-to-column code (bits 22:20) is 000. While `cfg_err` is high, every grant bit is low.
- R3: An activate (`req_cmd` = 1, grant bit 0) is granted only when the bank is idle. It is granted only once at least tRP clocks have passed since the last granted precharge, where the precharge cycle counts as the first clock and tRP equals its code, 1 to 7. A granted activate opens the bank.
- R4: A read (`req_cmd` = 2, grant bit 1) or a write (`req_cmd` = 3, grant bit 2) is granted only while the bank is open. It is granted only once at least tRCD clocks have passed since the activate, counted the same way. tRCD equals its code, 1 to 7.
- R5: A precharge (`req_cmd` = 4, grant bit 3) is granted only while the bank is open. It is granted only once at least tRAS clocks have passed since the activate. The tRAS code in bits 27:24 decodes as follows: codes 0 to 3 give 16 to 19 clocks, and codes 4 to 15 give the same number of clocks as the code. A granted precharge makes the bank idle.
- R6: A refresh (`req_cmd` = 5, grant bit 4) is granted only when the bank is idle and the tRP spacing since the last precharge has elapsed. A refresh leaves the bank idle.
- R7: A refused request changes neither the bank state nor any running spacing.
- R8: The configuration word is captured only in idle cycles that carry no grant. A change made while the bank is open takes effect only after the bank has returned to idle. A precharge keeps the tRP value captured before it.
- R9: Word bits 31, 23 and 19:0 have no effect on any output.
- R10: At most one grant bit is high at a time. Command codes 0, 6 and 7 are never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | 32 | Packed spacing configuration |
| req_cmd | input | 3 | Requested command: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| gnt | output | 5 | One bit per command kind, high in the cycle the request is accepted |
| cfg_err | output | 1 | Captured configuration holds a reserved code |

## Verification
A wrong bank state shows at the ports on the next request that depends on it. For example, an activate would be granted on an open bank, or a read would be granted on an idle one, in that very cycle. A spacing counter that is off by one shows only at the exact boundary cycle, where the grant appears one clock early or late. For that reason the directed part requests each dependent command on every cycle up to and past its limit. A configuration captured at the wrong time shows as a spacing that belongs to the previous or next setting, seen at the first boundary after the bank opens again.

// File: rtl/bank_guard_pkg.sv
// Shared command codes, grant bit positions and bank state type for the
// bank command timing guard. Assumes a 3-bit command request bus.
package bank_guard_pkg;

    localparam int CMD_W = 3;
    localparam int GNT_N = 5;

    localparam int GNT_ACT = 0;
    localparam int GNT_RD  = 1;
    localparam int GNT_WR  = 2;
    localparam int GNT_PRE = 3;
    localparam int GNT_REF = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP = CMD_W'(0),
        CMD_ACT = CMD_W'(1),
        CMD_RD  = CMD_W'(2),
        CMD_WR  = CMD_W'(3),
        CMD_PRE = CMD_W'(4),
        CMD_REF = CMD_W'(5)
    } bank_cmd_e;

    typedef enum logic {
        BANK_IDLE = 1'b0,
        BANK_OPEN = 1'b1
    } bank_state_e;

endpackage

// File: rtl/bank_cfg_latch.sv
// Captures the three spacing codes from the packed configuration word when
// allowed, decodes them into clock counts and flags reserved codes.
// Assumes the caller enables capture only while the bank is idle.
module bank_cfg_latch #(
    parameter int CFG_W    = 32,
    parameter int RP_LSB   = 28,
    parameter int RP_W     = 3,
    parameter int RAS_LSB  = 24,
    parameter int RAS_W    = 4,
    parameter int RAS_WRAP = 4,
    parameter int RCD_LSB  = 20,
    parameter int RCD_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic [CFG_W-1:0] cfg_word,
    output logic [RP_W-1:0]  rp_cyc,
    output logic [RAS_W:0]   ras_cyc,
    output logic [RCD_W-1:0] rcd_cyc,
    output logic             cfg_err
);

    localparam logic [CFG_W-1:0] FLD_MASK =
        (CFG_W'((1 << RP_W) - 1) << RP_LSB) |
        (CFG_W'((1 << RAS_W) - 1) << RAS_LSB) |
        (CFG_W'((1 << RCD_W) - 1) << RCD_LSB);
    localparam logic [RAS_W-1:0] RAS_WRAP_C = RAS_W'(RAS_WRAP);

    logic [RP_W-1:0]  rp_code_q;
    logic [RAS_W-1:0] ras_code_q;
    logic [RCD_W-1:0] rcd_code_q;
    logic             unused_cfg;

    // Bits outside the three fields are deliberately ignored.
    assign unused_cfg = ^(cfg_word & ~FLD_MASK);

    // Capture the raw codes in permitted cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_code_q  <= '0;
            ras_code_q <= '0;
            rcd_code_q <= '0;
        end else if (capture_en) begin
            rp_code_q  <= cfg_word[RP_LSB +: RP_W];
            ras_code_q <= cfg_word[RAS_LSB +: RAS_W];
            rcd_code_q <= cfg_word[RCD_LSB +: RCD_W];
        end
    end

    // Decode: low tRAS codes wrap to the top of the range, zero is reserved elsewhere.
    always_comb begin
        rp_cyc  = rp_code_q;
        rcd_cyc = rcd_code_q;
        ras_cyc = {(ras_code_q < RAS_WRAP_C), ras_code_q};
        cfg_err = (rp_code_q == '0) || (rcd_code_q == '0);
    end

endmodule

// File: rtl/bank_interval_timer.sv
// Down-counter for one minimum spacing. Loading N at an issue cycle makes
// done high again exactly N cycles later (issue cycle counted as the first).
// Assumes load_cyc is at least 1 whenever load is high.
module bank_interval_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cyc,
    output logic             done
);

    logic [CNT_W-1:0] count_q;

    // Reload on issue, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_cyc - CNT_W'(1);
        end else if (count_q != '0) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    assign done = (count_q == '0);

endmodule

// File: rtl/bank_cmd_guard.sv
// Single-bank SDRAM command guard: grants activate, read, write, precharge
// and refresh requests in the request cycle when the bank state and the
// three programmed spacings allow it. Assumes the requester retries refusals.
module bank_cmd_guard
    import bank_guard_pkg::*;
#(
    parameter int CFG_W    = 32,
    parameter int RP_LSB   = 28,
    parameter int RP_W     = 3,
    parameter int RAS_LSB  = 24,
    parameter int RAS_W    = 4,
    parameter int RAS_WRAP = 4,
    parameter int RCD_LSB  = 20,
    parameter int RCD_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [CMD_W-1:0] req_cmd,
    output logic [GNT_N-1:0] gnt,
    output logic             cfg_err
);

    bank_state_e      state_q;
    logic             bank_open;
    logic             capture_en;
    logic [RP_W-1:0]  rp_cyc;
    logic [RAS_W:0]   ras_cyc;
    logic [RCD_W-1:0] rcd_cyc;
    logic             rp_done;
    logic             ras_done;
    logic             rcd_done;

    assign bank_open  = (state_q == BANK_OPEN);
    assign capture_en = !bank_open && (gnt == '0);

    bank_cfg_latch #(
        .CFG_W(CFG_W), .RP_LSB(RP_LSB), .RP_W(RP_W),
        .RAS_LSB(RAS_LSB), .RAS_W(RAS_W), .RAS_WRAP(RAS_WRAP),
        .RCD_LSB(RCD_LSB), .RCD_W(RCD_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .cfg_word(cfg_word),
        .rp_cyc(rp_cyc), .ras_cyc(ras_cyc), .rcd_cyc(rcd_cyc), .cfg_err(cfg_err)
    );

    bank_interval_timer #(.CNT_W(RP_W)) u_rp_tmr (
        .clk(clk), .rst_n(rst_n), .load(gnt[GNT_PRE]),
        .load_cyc(rp_cyc), .done(rp_done)
    );

    bank_interval_timer #(.CNT_W(RAS_W + 1)) u_ras_tmr (
        .clk(clk), .rst_n(rst_n), .load(gnt[GNT_ACT]),
        .load_cyc(ras_cyc), .done(ras_done)
    );

    bank_interval_timer #(.CNT_W(RCD_W)) u_rcd_tmr (
        .clk(clk), .rst_n(rst_n), .load(gnt[GNT_ACT]),
        .load_cyc(rcd_cyc), .done(rcd_done)
    );

    // Grant decision for the current request.
    always_comb begin
        gnt = '0;
        if (!cfg_err) begin
            case (req_cmd)
                CMD_ACT: gnt[GNT_ACT] = !bank_open && rp_done;
                CMD_RD:  gnt[GNT_RD]  = bank_open && rcd_done;
                CMD_WR:  gnt[GNT_WR]  = bank_open && rcd_done;
                CMD_PRE: gnt[GNT_PRE] = bank_open && ras_done;
                CMD_REF: gnt[GNT_REF] = !bank_open && rp_done;
                default: gnt = '0;
            endcase
        end
    end

    // Bank state: opened by a granted activate, closed by a granted precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BANK_IDLE;
        end else if (gnt[GNT_ACT]) begin
            state_q <= BANK_OPEN;
        end else if (gnt[GNT_PRE]) begin
            state_q <= BANK_IDLE;
        end
    end

endmodule

// File: rtl/bank_cmd_guard_chk.sv
// Property checker for the bank command guard, bound to every instance.
// Assumes the top exposes bank_open and the decoded spacing values.
module bank_cmd_guard_chk
    import bank_guard_pkg::*;
#(
    parameter int RP_W  = 3,
    parameter int RAS_W = 4,
    parameter int RCD_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [GNT_N-1:0] gnt,
    input logic             cfg_err,
    input logic             bank_open,
    input logic [RP_W-1:0]  rp_cyc,
    input logic [RAS_W:0]   ras_cyc,
    input logic [RCD_W-1:0] rcd_cyc
);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R10
    AST_ERR_BLOCKS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (gnt == '0)); // R2
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[GNT_ACT] |=> bank_open); // R3
    AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[GNT_RD] || gnt[GNT_WR]) |-> bank_open); // R4
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[GNT_PRE] |=> !bank_open); // R5
    AST_NO_PRE_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[GNT_ACT] |=> !gnt[GNT_PRE]); // R5
    AST_REF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[GNT_REF] |=> !bank_open); // R6
    AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> $stable(bank_open)); // R7
    AST_CFG_FROZEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        bank_open |=> ($stable(rp_cyc) && $stable(ras_cyc) && $stable(rcd_cyc))); // R8

endmodule

bind bank_cmd_guard bank_cmd_guard_chk #(
    .RP_W(RP_W), .RAS_W(RAS_W), .RCD_W(RCD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .cfg_err(cfg_err),
    .bank_open(bank_open), .rp_cyc(rp_cyc), .ras_cyc(ras_cyc), .rcd_cyc(rcd_cyc)
);

// File: tb/bank_cmd_guard_tb_top.sv
// Self-checking bench: a behavioural model counts clocks since the last
// activate and precharge and predicts grants and the error flag each cycle.
module bank_cmd_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SAT        = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [2:0]  req_cmd = '0;
    logic [4:0]  gnt;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    int  lrp = 0, lras = 0, lrcd = 0;
    bit  m_open = 0;
    int  since_act = SAT, since_pre = SAT;
    int  need_rp = 0, need_rcd = 0, need_ras = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bank_cmd_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .req_cmd(req_cmd), .gnt(gnt), .cfg_err(cfg_err)
    );

    function automatic logic [31:0] mk_cfg(input int rp, input int ras, input int rcd);
        return (32'(rp & 7) << 28) | (32'(ras & 15) << 24) | (32'(rcd & 7) << 20);
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one request, compare against the model, then advance the model.
    task automatic step(input logic [2:0] cmd, input logic [31:0] cfg, input string tag);
        logic [4:0] eg;
        bit         eerr;
        @(negedge clk);
        req_cmd  = cmd;
        cfg_word = cfg;
        #1;
        eerr = (lrp == 0) || (lrcd == 0);
        eg   = '0;
        if (!eerr) begin
            case (cmd)
                3'd1: eg[0] = !m_open && (since_pre >= need_rp);
                3'd2: eg[1] = m_open && (since_act >= need_rcd);
                3'd3: eg[2] = m_open && (since_act >= need_rcd);
                3'd4: eg[3] = m_open && (since_act >= need_ras);
                3'd5: eg[4] = !m_open && (since_pre >= need_rp);
                default: eg = '0;
            endcase
        end
        chk(gnt === eg, tag, int'(gnt), int'(eg));
        chk(cfg_err === eerr, (tag == "R1") ? "R1" : "R2", int'(cfg_err), int'(eerr));
        if (!m_open && eg == '0) begin
            lrp  = int'(cfg[30:28]);
            lras = int'(cfg[27:24]);
            lrcd = int'(cfg[22:20]);
        end
        if (eg[0]) begin
            m_open    = 1;
            since_act = 1;
            need_rcd  = lrcd;
            need_ras  = (lras < 4) ? lras + 16 : lras;
        end else if (since_act < SAT) since_act++;
        if (eg[3]) begin
            m_open    = 0;
            since_pre = 1;
            need_rp   = lrp;
        end else if (since_pre < SAT) since_pre++;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] cfg_a, cfg_b, cfg_r;
        cfg_a = mk_cfg(3, 0, 2);
        cfg_b = mk_cfg(5, 5, 1) | 32'h8000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, nothing granted with zero configuration
        step(3'd1, 32'h0, "R1");
        step(3'd0, cfg_a, "R2");
        step(3'd1, cfg_a, "R3");
        // R4 boundary at tRCD = 2, R7 activate refused on open bank
        step(3'd2, cfg_a, "R4");
        step(3'd2, cfg_a, "R4");
        step(3'd1, cfg_b, "R7");
        // R5 wrapped code 0 = 16 clocks; new config held off while open (R8)
        repeat (13) step(3'd4, cfg_b, "R5");
        // R8: precharge keeps old tRP = 3 though new word asks for 5
        repeat (3) step(3'd1, cfg_b, "R8");
        step(3'd3, cfg_b, "R4");
        repeat (4) step(3'd4, cfg_b, "R5");
        // R6: refresh needs tRP = 5, leaves bank idle
        repeat (5) step(3'd5, cfg_b, "R6");
        step(3'd2, cfg_b, "R7");
        step(3'd1, cfg_b, "R6");
        // R10: unused codes never granted, open and idle
        step(3'd6, cfg_b, "R10");
        step(3'd7, cfg_b, "R10");
        step(3'd0, cfg_b, "R10");
        repeat (5) step(3'd4, cfg_b, "R5");
        step(3'd6, cfg_b, "R10");
        // R9: reserved bits set do not change behaviour
        cfg_r = mk_cfg(2, 4, 2) | 32'h808F_FFFF;
        repeat (6) step(3'd0, cfg_r, "R9");
        step(3'd1, cfg_r, "R9");
        step(3'd2, cfg_r, "R9");
        step(3'd2, cfg_r, "R9");
        repeat (3) step(3'd4, cfg_r, "R9");
        // R2: reserved zero codes block everything
        step(3'd0, mk_cfg(0, 4, 2), "R2");
        step(3'd1, mk_cfg(0, 4, 2), "R2");
        step(3'd5, mk_cfg(3, 4, 0), "R2");
        step(3'd1, mk_cfg(3, 4, 0), "R2");
        step(3'd0, mk_cfg(1, 4, 1), "R2");
        step(3'd1, mk_cfg(1, 4, 1), "R3");
        // random traffic
        cfg_r = mk_cfg(2, 6, 3);
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] c;
            if ($urandom_range(0, 19) == 0)
                cfg_r = mk_cfg($urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 7))
                        | ($urandom_range(0, 1) == 1 ? 32'h0080_0001 : 32'h0);
            c = 3'($urandom_range(0, 7));
            step(c, cfg_r, tag_of(c));
        end
        summary();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule